// File: doc/BRIEF.md
# Shared-Unit Multiply-Add Datapath

This block evaluates z = a × b + (c + d) for a stream of unsigned operand sets. It has only one multiplier and one adder. The adder does two jobs for every set. First it forms the partial sum c + d, which goes into a holding register y. Later it adds the registered product x to y and writes the final result register z. Two input multiplexers pick what the adder sees, and a result demultiplexer sends the sum to either y or z. A small controller drives the datapath with a handful of strobes: operand load, product load, partial-sum load, result load and the adder select.

A mode input picks one of two schedules. In the overlapped schedule the controller alternates between two phases. The partial sum of one set shares a phase with the product capture of the same set, while the next set is being loaded. This gives one result every two cycles. In the serial schedule the product, the partial sum and the final sum each get a cycle of their own, so a new set is taken only every third cycle. An operand set is accepted in a cycle where both `inValid` and `inReady` are high. Each result appears as a one-cycle `outValid` pulse with the value on `zOut`.

Top module: `shared_muladd`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `inReady` is 1, `outValid` is 0 and `zOut` is 0.
- R2: Every result on `zOut` equals a × b + c + d of the accepted set, computed unsigned and at full width (2·W+1 bits), so it never wraps. The adder never loads y and z in the same cycle.
- R3: With `overlapMode` = 1, `inReady` is high in every other cycle, starting with the first cycle after reset. A set accepted in cycle T produces `outValid` in cycle T+4.
- R4: With `overlapMode` = 0, `inReady` is high in one cycle out of three. A set accepted in cycle T produces `outValid` in cycle T+5.
- R5: Sets offered back to back come out in order, at one result per 2 cycles when overlapped and per 3 cycles when serial. For n sets, the last `outValid` comes 2(n−1)+4 cycles after the first acceptance when overlapped, and 3(n−1)+5 cycles after it when serial.
- R6: `inValid` in a cycle where `inReady` is 0 is ignored: no result is produced for it.
- R7: Each accepted set gives exactly one `outValid` pulse, one cycle long. `zOut` changes only in the cycle where `outValid` rises and holds its value until the next pulse.
- R8: `overlapMode` may change only when no set is in flight. The next set accepted after a change follows the timing of the new mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| overlapMode | input | 1 | 1 = overlapped two-phase schedule, 0 = serial three-phase schedule |
| inValid | input | 1 | An operand set is offered |
| inReady | output | 1 | The block takes an offered set at the end of this cycle |
| aIn | input | W | Multiplicand |
| bIn | input | W | Multiplier |
| cIn | input | W | First addend |
| dIn | input | W | Second addend |
| zOut | output | 2·W+1 | Result register |
| outValid | output | 1 | One-cycle pulse marking a new result on `zOut` |

## Verification
Most internal faults show up at the ports within one result period. If a product or partial sum is captured from the wrong set, or in the wrong phase, a value from a neighbouring set leaks into `zOut`. If the adder select or the demultiplexer is swapped, y gets overwritten or z gets loaded with c + d. If the controller phase drifts, `inReady` breaks its 2- or 3-cycle pattern and `outValid` lands off its fixed T+4 or T+5 slot. The scoreboard checks value, order and the exact cycle of each result. A stray or missing pulse therefore fails the check for that very set, and a late result also shifts the end of a burst.

// File: rtl/muladd_pkg.sv
package muladd_pkg;
  // Strobes from the controller to the datapath, all active high.
  typedef struct packed {
    logic ldIn;    // capture all four operand ports
    logic ldX;     // capture product stage into x
    logic ldY;     // adder result -> y (demux side 0)
    logic ldZ;     // adder result -> z (demux side 1)
    logic addSel;  // 0: adder sees c,d ; 1: adder sees x,y ; also demux select
  } strobe_t;
endpackage

// File: rtl/muladd_ctrl.sv
module muladd_ctrl
  import muladd_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    overlapMode,
  input  logic    inValid,
  output logic    inReady,
  output strobe_t strobes
);
  localparam int STAGES = 4;

  typedef enum logic [1:0] {PH_LOAD, PH_MID, PH_LAST} phase_t;

  phase_t             phase, phaseNext;
  logic [STAGES:1]    inFlight;   // bit k: a set accepted k cycles ago

  always_comb begin
    case (phase)
      PH_LOAD: phaseNext = PH_MID;
      PH_MID:  phaseNext = overlapMode ? PH_LOAD : PH_LAST;
      default: phaseNext = PH_LOAD;
    endcase
  end

  assign inReady = (phase == PH_LOAD);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_LOAD;
      inFlight <= '0;
    end else begin
      phase    <= phaseNext;
      inFlight <= {inFlight[STAGES-1:1], strobes.ldIn};
    end
  end

  always_comb begin
    strobes.ldIn = inValid && inReady;
    strobes.ldX  = inFlight[2];
    if (overlapMode) begin
      // phase A: product capture and c+d together; phase B: x+y
      strobes.ldY    = inFlight[2];
      strobes.ldZ    = inFlight[3];
      strobes.addSel = inFlight[3];
    end else begin
      // one step per cycle: x, then y, then z
      strobes.ldY    = inFlight[3];
      strobes.ldZ    = inFlight[4];
      strobes.addSel = inFlight[4];
    end
  end
endmodule

// File: rtl/muladd_dp.sv
module muladd_dp
  import muladd_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strobes,
  input  logic [W-1:0]      aIn,
  input  logic [W-1:0]      bIn,
  input  logic [W-1:0]      cIn,
  input  logic [W-1:0]      dIn,
  output logic [2*W:0]      zOut,
  output logic              outValid
);
  localparam int PW = 2 * W;
  localparam int YW = W + 1;
  localparam int ZW = 2 * W + 1;
  localparam int NOPS = 4;

  logic [W-1:0]  opIn  [NOPS];
  logic [W-1:0]  opReg [NOPS];
  logic [PW-1:0] prodStage, xReg;
  logic [YW-1:0] yReg;
  logic [ZW-1:0] zReg, addL, addR, sum;

  assign opIn[0] = aIn;
  assign opIn[1] = bIn;
  assign opIn[2] = cIn;
  assign opIn[3] = dIn;

  for (genvar i = 0; i < NOPS; i++) begin : g_opnd
    always_ff @(posedge clk) begin
      if (rst)               opReg[i] <= '0;
      else if (strobes.ldIn) opReg[i] <= opIn[i];
    end
  end

  // Two-cycle multiplier: stage register, then x.
  always_ff @(posedge clk) begin
    if (rst) begin
      prodStage <= '0;
      xReg      <= '0;
    end else begin
      prodStage <= PW'(opReg[0]) * PW'(opReg[1]);
      if (strobes.ldX) xReg <= prodStage;
    end
  end

  // Input multiplexers of the single shared adder.
  always_comb begin
    if (strobes.addSel) begin
      addL = {{(ZW-PW){1'b0}}, xReg};
      addR = {{(ZW-YW){1'b0}}, yReg};
    end else begin
      addL = {{(ZW-W){1'b0}}, opReg[2]};
      addR = {{(ZW-W){1'b0}}, opReg[3]};
    end
  end

  assign sum = addL + addR;

  // Result demultiplexer.
  always_ff @(posedge clk) begin
    if (rst) begin
      yReg     <= '0;
      zReg     <= '0;
      outValid <= 1'b0;
    end else begin
      if (strobes.ldY && !strobes.addSel) yReg <= sum[YW-1:0];
      if (strobes.ldZ && strobes.addSel)  zReg <= sum;
      outValid <= strobes.ldZ;
    end
  end

  assign zOut = zReg;
endmodule

// File: rtl/shared_muladd.sv
module shared_muladd
  import muladd_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         overlapMode,
  input  logic         inValid,
  output logic         inReady,
  input  logic [W-1:0] aIn,
  input  logic [W-1:0] bIn,
  input  logic [W-1:0] cIn,
  input  logic [W-1:0] dIn,
  output logic [2*W:0] zOut,
  output logic         outValid
);
  strobe_t strobes;

  muladd_ctrl u_ctrl (
    .clk(clk), .rst(rst), .overlapMode(overlapMode),
    .inValid(inValid), .inReady(inReady), .strobes(strobes)
  );

  muladd_dp #(.W(W)) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes),
    .aIn(aIn), .bIn(bIn), .cIn(cIn), .dIn(dIn),
    .zOut(zOut), .outValid(outValid)
  );
endmodule

// File: rtl/muladd_checker.sv
module muladd_checker
  import muladd_pkg::*;
#(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         overlapMode,
  input logic         inReady,
  input logic         outValid,
  input logic [2*W:0] zOut,
  input strobe_t      strobes
);
  // R3: a ready cycle is always followed by a non-ready one
  p_ready_gap_r3: assert property (@(posedge clk) disable iff (rst)
    inReady |=> !inReady);

  // R4: serial mode leaves two idle cycles after each ready cycle
  p_ready_third_r4: assert property (@(posedge clk) disable iff (rst)
    (inReady && !overlapMode) ##1 !overlapMode |=> !inReady);

  // R6: operands are captured only when ready
  p_accept_ready_r6: assert property (@(posedge clk) disable iff (rst)
    strobes.ldIn |-> inReady);

  // R2: the shared adder serves at most one destination per cycle
  p_adder_single_r2: assert property (@(posedge clk) disable iff (rst)
    !(strobes.ldY && strobes.ldZ));

  // R7: a result load is announced in the next cycle
  p_valid_after_load_r7: assert property (@(posedge clk) disable iff (rst)
    strobes.ldZ |=> outValid);

  // R7: the valid flag is a single-cycle pulse
  p_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    outValid |=> !outValid);

  // R7: the result holds unless a load was requested
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !strobes.ldZ |=> $stable(zOut));
endmodule

bind shared_muladd muladd_checker #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .overlapMode(overlapMode), .inReady(inReady),
  .outValid(outValid), .zOut(zOut), .strobes(strobes)
);

// File: tb/shared_muladd_test.sv
module shared_muladd_test;
  localparam int W  = 8;
  localparam int ZW = 2 * W + 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          overlapMode = 1'b1;
  logic          inValid = 1'b0;
  logic          inReady;
  logic [W-1:0]  aIn = '0, bIn = '0, cIn = '0, dIn = '0;
  logic [ZW-1:0] zOut;
  logic          outValid;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int outCount = 0;
  int lastOut  = 0;
  int firstAccept = 0;
  bit done = 0;
  logic [ZW-1:0] heldZ = '0;

  logic [ZW-1:0] expZ [$];
  int            expCyc [$];
  bit            expOvl [$];

  shared_muladd #(.W(W)) uut (
    .clk(clk), .rst(rst), .overlapMode(overlapMode), .inValid(inValid),
    .inReady(inReady), .aIn(aIn), .bIn(bIn), .cIn(cIn), .dIn(dIn),
    .zOut(zOut), .outValid(outValid)
  );

  always #2 clk = ~clk;   // 250 MHz

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic finishRun();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  endtask

  // Driver: offer a set, wait for acceptance, push expected result.
  task automatic sendSet(input logic [W-1:0] a, b, c, d, output int acc);
    aIn = a; bIn = b; cIn = c; dIn = d; inValid = 1'b1;
    while (!inReady) @(negedge clk);
    acc = cyc;
    expZ.push_back(ZW'(a) * ZW'(b) + ZW'(c) + ZW'(d));
    expCyc.push_back(cyc + (overlapMode ? 4 : 5));
    expOvl.push_back(overlapMode);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    inValid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // Monitor / scoreboard.
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (outValid) begin
        if (expZ.size() == 0) begin
          check(1'b0, "R6", "unexpected outValid", 1, 0);
        end else begin
          logic [ZW-1:0] e;
          int ec;
          bit eo;
          e  = expZ.pop_front();
          ec = expCyc.pop_front();
          eo = expOvl.pop_front();
          check(zOut == e, "R2", "result value", zOut, e);
          check(cyc == ec, eo ? "R3" : "R4", "result cycle", cyc, ec);
        end
        outCount++;
        lastOut = cyc;
        heldZ = zOut;
      end else begin
        check(zOut == heldZ, "R7", "zOut hold", zOut, heldZ);
      end
    end
  end

  // Watchdog.
  always @(posedge clk) begin
    if (cyc > 20000 && !done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
      finishRun();
    end
  end

  initial begin
    int acc;
    int cnt0;
    repeat (4) @(negedge clk);
    check(inReady == 1'b1, "R1", "inReady during reset", inReady, 1);
    check(outValid == 1'b0, "R1", "outValid during reset", outValid, 0);
    rst = 1'b0;
    check(inReady == 1'b1, "R1", "inReady after reset", inReady, 1);
    check(outValid == 1'b0, "R1", "outValid after reset", outValid, 0);
    check(zOut == '0, "R1", "zOut after reset", zOut, 0);

    // R3: single set, overlapped
    overlapMode = 1'b1;
    sendSet(8'd3, 8'd4, 8'd5, 8'd6, acc);
    idle(10);
    // R2: full-width corner
    sendSet(8'hFF, 8'hFF, 8'hFF, 8'hFF, acc);
    idle(10);

    // R5: burst of four, overlapped
    sendSet(8'd10, 8'd20, 8'd1, 8'd2, acc);
    firstAccept = acc;
    sendSet(8'd7, 8'd9, 8'd200, 8'd100, acc);
    sendSet(8'd0, 8'd55, 8'd33, 8'd44, acc);
    sendSet(8'd128, 8'd2, 8'd255, 8'd0, acc);
    idle(10);
    check(lastOut - firstAccept == 10, "R5", "overlapped burst span",
          lastOut - firstAccept, 10);

    // R6: offer a set only while not ready
    while (inReady) @(negedge clk);
    cnt0 = outCount;
    aIn = 8'hAA; bIn = 8'hBB; cIn = 8'hCC; dIn = 8'hDD; inValid = 1'b1;
    @(negedge clk);
    idle(10);
    check(outCount == cnt0, "R6", "results after ignored offer", outCount, cnt0);

    // R8 / R4: switch to serial when drained
    overlapMode = 1'b0;
    cnt0 = outCount;
    sendSet(8'd12, 8'd11, 8'd9, 8'd8, acc);
    idle(10);
    check(outCount == cnt0 + 1 && expZ.size() == 0, "R8",
          "serial result after switch", outCount, cnt0 + 1);

    // R5: burst of four, serial
    sendSet(8'd1, 8'd1, 8'd1, 8'd1, acc);
    firstAccept = acc;
    sendSet(8'd250, 8'd3, 8'd7, 8'd9, acc);
    sendSet(8'd0, 8'd0, 8'd0, 8'd0, acc);
    sendSet(8'd99, 8'd101, 8'd128, 8'd127, acc);
    idle(12);
    check(lastOut - firstAccept == 14, "R5", "serial burst span",
          lastOut - firstAccept, 14);

    // R8: back to overlapped
    overlapMode = 1'b1;
    cnt0 = outCount;
    sendSet(8'd17, 8'd19, 8'd23, 8'd29, acc);
    idle(10);
    check(outCount == cnt0 + 1 && expZ.size() == 0, "R8",
          "overlapped result after switch", outCount, cnt0 + 1);

    check(expZ.size() == 0, "R7", "all sets answered", expZ.size(), 0);
    finishRun();
  end
endmodule